// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt causes from a set of peripheral sources and holds a sticky pending flag for each one. Every source carries its own enable bit and a three-bit priority level written through a small register-write port. Among the sources that are both pending and enabled, the block picks one winner. The highest level wins, and on equal levels the lowest source index wins. The winner goes to the processor core as a single registered request, with its level and a vector number (a base value plus the source index).

The request is raised only when all of these hold at once: the controller-wide enable is set, the core's interrupt-enable status bit is set, no non-maskable interrupt is active, and the winner's level is strictly above the core's current interrupt level. A pending flag that cannot be forwarded stays set. It appears at the core as soon as every gating condition becomes true. Each source is either edge type or level type, fixed by a parameter. An edge flag latches on a rising edge of its cause and is cleared by software. A level flag tracks its cause input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the request, level and vector outputs are 0. The controller enable, all source enables, all levels and all flags are 0, so a cause seen before any configuration raises no request.
- R2: An edge-type source sets its flag on a rising edge of its cause. The flag stays set after the cause falls. The request shows up at the second rising clock edge after the cause is first sampled high.
- R3: A write of kind 2 clears each edge flag whose data bit is 1. Bits written as 0 leave their flags unchanged. A rising edge of the cause in the same cycle as a clear keeps the flag set.
- R4: A level-type source's flag follows its cause input one cycle late, and a kind-2 clear write does not affect it.
- R5: A request reaches the core only while the controller enable (bit 0 of a kind-0 write) is 1.
- R6: A source takes part only while its bit in the enable mask (a kind-1 write, bit i for source i) is 1.
- R7: No request is raised while the core interrupt-enable input is 0.
- R8: A request is raised only when the winning level is strictly greater than the core's current level input. An equal level is blocked.
- R9: No request is raised while the non-maskable-interrupt active input is 1.
- R10: A flag held back by any gate is kept. The request rises one clock edge after the last gating condition becomes true.
- R11: Among pending enabled sources, the highest level (set by a kind-3 write to the source at the given index, data bits [2:0]) wins. Equal levels go to the lowest index. Losers stay pending and win once the higher ones are cleared.
- R12: While the request is 1, the vector output equals the vector base plus the winning index and the level output equals the winner's level. While the request is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cause_i | input | NSRC | Raw interrupt cause per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write kind: 0 control, 1 enable mask, 2 flag clear, 3 source level |
| wr_idx_i | input | $clog2(NSRC) | Source index for a level write |
| wr_data_i | input | NSRC | Write data |
| core_ie_i | input | 1 | Core interrupt-enable status bit |
| core_il_i | input | LVLW | Core current interrupt level |
| nmi_i | input | 1 | Non-maskable interrupt active |
| irq_req_o | output | 1 | Registered interrupt request to the core |
| irq_lvl_o | output | LVLW | Level of the forwarded request |
| irq_vec_o | output | VECW | Vector number of the forwarded request |

## Verification
A flag wrongly dropped shows up as a request that falls without any clear write. A flag that will not clear shows up as a request that stays high. Either one is visible one clock edge after the clear would have landed. A wrong arbitration or level-compare decision shows up right away as the wrong vector, the wrong level, or a missing request at the next registered output. For that reason, the bench reads the outputs one edge after each gate change and two edges after each cause change, and walks through clears of staggered winners so that every held-back loser has to come out.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Kind of register write on the configuration port.
    typedef enum logic [1:0] {
        WR_CTRL   = 2'd0,
        WR_ENABLE = 2'd1,
        WR_CLEAR  = 2'd2,
        WR_LEVEL  = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NSRC = 8,
    parameter int LVLW = 3,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_kind_i,
    input  logic [IDXW-1:0]            wr_idx_i,
    input  logic [NSRC-1:0]            wr_data_i,
    output logic                       gen_en_o,
    output logic [NSRC-1:0]            src_en_o,
    output logic [NSRC-1:0][LVLW-1:0]  src_lvl_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic                      gen_en;
        logic [NSRC-1:0]           src_en;
        logic [NSRC-1:0][LVLW-1:0] src_lvl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_kind_i)
                WR_CTRL:   cfg_d.gen_en = wr_data_i[0];
                WR_ENABLE: cfg_d.src_en = wr_data_i;
                WR_LEVEL: begin
                    if (int'(wr_idx_i) < NSRC)
                        cfg_d.src_lvl[wr_idx_i] = wr_data_i[LVLW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign gen_en_o  = cfg_q.gen_en;
    assign src_en_o  = cfg_q.src_en;
    assign src_lvl_o = cfg_q.src_lvl;

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
    parameter int              NSRC       = 8,
    parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cause_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] prev;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d.prev = cause_i;
        for (int i = 0; i < NSRC; i++) begin
            if (LEVEL_MASK[i])
                st_d.flag[i] = cause_i[i];
            else
                st_d.flag[i] = (cause_i[i] & ~st_q.prev[i]) |
                               (st_q.flag[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // Edge flags are sticky: only a clear write can drop them.
    for (genvar g = 0; g < NSRC; g++) begin : g_sticky
        if (!LEVEL_MASK[g]) begin : g_edge
            a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.flag[g] && !clr_i[g]) |=> st_q.flag[g]);
            a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !cause_i[g]) |=> !st_q.flag[g]);
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 8,
    parameter int LVLW = 3,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]           cand_i,
    input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
    output logic                      win_valid_o,
    output logic [IDXW-1:0]           win_idx_o,
    output logic [LVLW-1:0]           win_lvl_o
);

    // Linear scan: a later source replaces the current best only with a
    // strictly higher level, so ties stay with the lowest index.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand_i[i] && (!win_valid_o || (lvl_i[i] > win_lvl_o))) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDXW'(i);
                win_lvl_o   = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int              NSRC       = 8,
    parameter int              LVLW       = 3,
    parameter int              VECW       = 8,
    parameter int              VEC_BASE   = 32,
    parameter logic [NSRC-1:0] LEVEL_MASK = 8'b1100_0000,
    localparam int             IDXW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cause_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_kind_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic [NSRC-1:0] wr_data_i,
    input  logic            core_ie_i,
    input  logic [LVLW-1:0] core_il_i,
    input  logic            nmi_i,
    output logic            irq_req_o,
    output logic [LVLW-1:0] irq_lvl_o,
    output logic [VECW-1:0] irq_vec_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic            req;
        logic [LVLW-1:0] lvl;
        logic [VECW-1:0] vec;
    } out_t;

    logic                      gen_en;
    logic [NSRC-1:0]           src_en;
    logic [NSRC-1:0][LVLW-1:0] src_lvl;
    logic [NSRC-1:0]           clr_mask;
    logic [NSRC-1:0]           flags;
    logic [NSRC-1:0]           cand;
    logic                      win_valid;
    logic [IDXW-1:0]           win_idx;
    logic [LVLW-1:0]           win_lvl;
    logic                      fire;
    out_t                      out_d, out_q;

    irq_cfg_regs #(.NSRC(NSRC), .LVLW(LVLW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_kind_i (wr_kind_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .gen_en_o  (gen_en),
        .src_en_o  (src_en),
        .src_lvl_o (src_lvl)
    );

    assign clr_mask = (wr_en_i && (wr_kind_i == WR_CLEAR)) ? wr_data_i : '0;

    irq_flags #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_i),
        .clr_i   (clr_mask),
        .flag_o  (flags)
    );

    assign cand = flags & src_en;

    irq_arbiter #(.NSRC(NSRC), .LVLW(LVLW)) u_arb (
        .cand_i      (cand),
        .lvl_i       (src_lvl),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    always_comb begin
        fire      = win_valid && gen_en && core_ie_i && !nmi_i &&
                    (win_lvl > core_il_i);
        out_d.req = fire;
        out_d.lvl = fire ? win_lvl : '0;
        out_d.vec = fire ? (VECW'(VEC_BASE) + VECW'(win_idx)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_req_o = out_q.req;
    assign irq_lvl_o = out_q.lvl;
    assign irq_vec_o = out_q.vec;

    // R5 R7 R9: a request implies the gates were open at the prior edge.
    a_r5_r7_r9_gates_open: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> $past(gen_en && core_ie_i && !nmi_i));

    a_r8_above_core_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_lvl_o > $past(core_il_i)));

    a_r11_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> cand[win_idx]);

    a_r12_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_vec_o == '0 && irq_lvl_o == '0));

    a_r12_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (int'(irq_vec_o) >= VEC_BASE && int'(irq_vec_o) < VEC_BASE + NSRC));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    localparam int NSRC = 8;
    localparam int LVLW = 3;
    localparam int VECW = 8;
    localparam int VB   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] cause = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_kind = '0;
    logic [2:0]      wr_idx = '0;
    logic [NSRC-1:0] wr_data = '0;
    logic            core_ie = 1'b0;
    logic [LVLW-1:0] core_il = '0;
    logic            nmi = 1'b0;
    logic            req;
    logic [LVLW-1:0] lvl;
    logic [VECW-1:0] vec;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW), .VEC_BASE(VB),
                    .LEVEL_MASK(8'b1100_0000)) u_irq_prio_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_i   (cause),
        .wr_en_i   (wr_en),
        .wr_kind_i (wr_kind),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .core_ie_i (core_ie),
        .core_il_i (core_il),
        .nmi_i     (nmi),
        .irq_req_o (req),
        .irq_lvl_o (lvl),
        .irq_vec_o (vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] idx, input logic [7:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [7:0] m);
        cause = cause | m;
        step(1);
        cause = cause & ~m;
    endtask

    task automatic t_reset();
        chk("R1 req", int'(req), 0);
        chk("R1 vec", int'(vec), 0);
        chk("R1 lvl", int'(lvl), 0);
        core_ie = 1'b1;
        pulse(8'h01);
        step(1);
        chk("R1 unconfigured cause", int'(req), 0);
        wr(2'd2, 0, 8'hFF);
        core_ie = 1'b0;
    endtask

    task automatic setup();
        wr(2'd0, 0, 8'h01);
        wr(2'd3, 0, 8'd3);
        wr(2'd3, 1, 8'd5);
        wr(2'd3, 2, 8'd5);
        wr(2'd3, 3, 8'd2);
        wr(2'd3, 6, 8'd4);
        wr(2'd1, 0, 8'h4F);
        core_ie = 1'b1;
        core_il = '0;
        step(1);
    endtask

    task automatic t_edge();
        pulse(8'h01);
        step(1);
        chk("R2 req after edge", int'(req), 1);
        chk("R12 vec src0", int'(vec), VB + 0);
        chk("R12 lvl src0", int'(lvl), 3);
        step(5);
        chk("R2 sticky after cause low", int'(req), 1);
        wr(2'd2, 0, 8'h01);
        step(1);
        chk("R3 cleared", int'(req), 0);
    endtask

    task automatic t_clear();
        pulse(8'h01);
        step(1);
        wr(2'd2, 0, 8'hFE);
        step(1);
        chk("R3 zero bit keeps flag", int'(req), 1);
        chk("R3 zero bit keeps vec", int'(vec), VB + 0);
        wr(2'd2, 0, 8'h01);
        step(1);
        chk("R3 clear", int'(req), 0);
        cause[0] = 1'b1;
        wr_en = 1'b1; wr_kind = 2'd2; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; cause[0] = 1'b0;
        step(1);
        chk("R3 set wins over clear", int'(req), 1);
        wr(2'd2, 0, 8'h01);
        step(1);
        chk("R3 clear after set", int'(req), 0);
    endtask

    task automatic t_level();
        cause[6] = 1'b1;
        step(2);
        chk("R4 level req", int'(req), 1);
        chk("R4 level vec", int'(vec), VB + 6);
        chk("R4 level lvl", int'(lvl), 4);
        wr(2'd2, 0, 8'h40);
        step(1);
        chk("R4 clear ignored", int'(req), 1);
        cause[6] = 1'b0;
        step(2);
        chk("R4 follows input low", int'(req), 0);
    endtask

    task automatic t_gates();
        pulse(8'h01);
        step(1);
        chk("R10 pending base", int'(req), 1);
        wr(2'd0, 0, 8'h00);
        step(1);
        chk("R5 global off", int'(req), 0);
        wr(2'd0, 0, 8'h01);
        step(1);
        chk("R10 global back", int'(req), 1);
        core_ie = 1'b0;
        step(1);
        chk("R7 core ie off", int'(req), 0);
        core_ie = 1'b1;
        step(1);
        chk("R10 ie back", int'(req), 1);
        nmi = 1'b1;
        step(1);
        chk("R9 nmi blocks", int'(req), 0);
        nmi = 1'b0;
        step(1);
        chk("R10 nmi gone", int'(req), 1);
        wr(2'd1, 0, 8'h4E);
        step(1);
        chk("R6 source disabled", int'(req), 0);
        wr(2'd1, 0, 8'h4F);
        step(1);
        chk("R10 source enabled", int'(req), 1);
        chk("R10 vec", int'(vec), VB + 0);
    endtask

    task automatic t_levelcmp();
        core_il = 3'd3;
        step(1);
        chk("R8 equal level blocked", int'(req), 0);
        core_il = 3'd2;
        step(1);
        chk("R8 higher level passes", int'(req), 1);
        chk("R8 lvl", int'(lvl), 3);
        core_il = 3'd0;
        wr(2'd2, 0, 8'h01);
        step(1);
        chk("R3 cleared before prio", int'(req), 0);
    endtask

    task automatic t_prio();
        pulse(8'h0F);
        step(1);
        chk("R11 tie lowest index", int'(vec), VB + 1);
        chk("R11 level 5", int'(lvl), 5);
        wr(2'd2, 0, 8'h02);
        step(1);
        chk("R11 next tie", int'(vec), VB + 2);
        wr(2'd2, 0, 8'h04);
        step(1);
        chk("R11 level 3 src0", int'(vec), VB + 0);
        chk("R11 lvl 3", int'(lvl), 3);
        wr(2'd2, 0, 8'h01);
        step(1);
        chk("R11 last loser", int'(vec), VB + 3);
        core_il = 3'd2;
        step(1);
        chk("R8 loser blocked", int'(req), 0);
        core_il = 3'd0;
        step(1);
        chk("R10 loser kept", int'(vec), VB + 3);
        wr(2'd3, 3, 8'd6);
        step(1);
        chk("R11 new level", int'(lvl), 6);
        pulse(8'h01);
        step(1);
        chk("R11 level beats index", int'(vec), VB + 3);
        wr(2'd2, 0, 8'h09);
        step(1);
        chk("R12 idle req", int'(req), 0);
        chk("R12 idle vec", int'(vec), 0);
        chk("R12 idle lvl", int'(lvl), 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        setup();
        t_edge();
        t_clear();
        t_level();
        t_gates();
        t_levelcmp();
        t_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule